// File: doc/BRIEF.md
# Multi-bank GPIO port with APB register window

This block lets a processor drive and sample up to four banks of general-purpose pins through a single APB slave window. Each bank has three registers. The output value register sets the level driven on each pin. The direction register turns each pin's output enable on or off. A read-only sample register shows the pin levels after they have passed through a two-flop synchroniser.

The number of pins in each bank is set by a parameter, from 0 to 32. A width of 0 leaves the bank out. Every bank keeps its register addresses whether its neighbours are present or not. With the default widths (8, 16, absent, 30), a map with a gap at bank 2 keeps banks 0, 1 and 3 at their usual offsets.

On the pin side, bank n uses lane n of three 128-bit buses: bits 32n through 32n+31 of `gpio_in`, `gpio_out` and `gpio_oe`. The pin-side logic of the chip takes only as many bits from each lane as the bank has pins.

Top module: `gpio_banks`

## Requirements
- R1: The output value register of bank n is at byte offset 12*n (word 3n). A write sets `gpio_out` lane n from the cycle after the write. A read returns the stored value.
- R2: The direction register of bank n is at byte offset 12*n+4 (word 3n+1). A 1 in bit i drives `gpio_oe` bit 32n+i high, which makes that pin an output. The register reads back as it was written.
- R3: The sample register of bank n is at byte offset 0x50+4*n (word 20+n) and is read-only. It shows each pin's level through two flops. After a change on a pin, a read whose access phase falls before the second rising edge returns the old level. Any read from the third edge onward returns the new level.
- R4: Register bits at or above a bank's pin count read as 0 and are not changed by writes. The matching `gpio_out`, `gpio_oe` and sample bits stay 0.
- R5: A bank with width 0 is absent. All of its registers read 0, writes to it have no effect, and its `gpio_out` and `gpio_oe` lanes stay 0.
- R6: Reset, with `presetn` low, clears every output value and direction register. Every pin therefore starts as an input with output value 0.
- R7: Every transfer completes in its access phase with `pready` high and `pslverr` low.
- R8: A register changes only on a transfer with `psel`, `penable` and `pwrite` all high. A setup phase alone, a read, or a write to a sample register leaves all outputs and registers unchanged.
- R9: Unmapped words read 0, and writes to them have no effect. These are word 3n+2 of each bank, offsets 0x30 to 0x4C, and anything from 0x60 upward. Address bits [1:0] are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | APB clock |
| presetn | input | 1 | Active-low reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W | Byte address within the window |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, 0 when not selected |
| pready | output | 1 | Transfer complete, always high |
| pslverr | output | 1 | Error response, always low |
| gpio_in | input | 128 | Pin levels, bank n in bits 32n+31:32n |
| gpio_out | output | 128 | Output values, bank n in bits 32n+31:32n |
| gpio_oe | output | 128 | Output enables, 1 = drive pin |

## Verification
Output values and directions are written with patterns that differ per bank:
- all-ones words show where each bank's width cuts off;
- a narrow nibble pattern in bank 0 and a 16-bit word in bank 1 show that lanes do not cross-couple;
- a word with bit 31 and bit 0 set on the 30-pin bank shows that the top bits are dropped and the low bit kept.

Pin inputs are moved from all-zero to a known pattern while a read is in flight, which separates the first-edge sample from the second-edge one. Writes that go to the absent bank, to unmapped words, to a sample register, or that stop after the setup phase are each followed by read-back and output checks. These show the write landed nowhere.

// File: rtl/gpio_banks.sv
module gpio_banks #(
  parameter int W0     = 8,
  parameter int W1     = 16,
  parameter int W2     = 0,
  parameter int W3     = 30,
  parameter int ADDR_W = 8
) (
  input  logic              pclk,
  input  logic              presetn,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [31:0]       pwdata,
  output logic [31:0]       prdata,
  output logic              pready,
  output logic              pslverr,
  input  logic [127:0]      gpio_in,
  output logic [127:0]      gpio_out,
  output logic [127:0]      gpio_oe
);

  localparam int NB = 4;
  localparam int WA = ADDR_W - 2;
  localparam int IN_BASE = 20;
  localparam int WIDTHS [NB] = '{W0, W1, W2, W3};

  function automatic logic [31:0] lane_mask(input int w);
    if (w >= 32) return '1;
    if (w <= 0)  return '0;
    return (32'd1 << w) - 32'd1;
  endfunction

  localparam logic [127:0] PIN_MASK =
    {lane_mask(W3), lane_mask(W2), lane_mask(W1), lane_mask(W0)};

  logic          wr_en;
  logic [WA-1:0] word;
  logic [31:0]   rd_lane [NB];
  logic [1:0]    unused_lsb;

  assign wr_en      = psel & penable & pwrite;
  assign word       = paddr[ADDR_W-1:2];
  assign unused_lsb = paddr[1:0];
  assign pready     = 1'b1;
  assign pslverr    = 1'b0;

  for (genvar b = 0; b < NB; b++) begin : g_bank
    localparam logic [31:0]   M  = lane_mask(WIDTHS[b]);
    localparam logic [WA-1:0] DW = WA'(3 * b);
    localparam logic [WA-1:0] RW = WA'(3 * b + 1);
    localparam logic [WA-1:0] IW = WA'(IN_BASE + b);

    if (WIDTHS[b] > 0) begin : g_on
      logic [31:0] dout_q, dir_q, s1_q, s2_q;

      always_ff @(posedge pclk or negedge presetn) begin
        if (!presetn) begin
          dout_q <= '0;
          dir_q  <= '0;
          s1_q   <= '0;
          s2_q   <= '0;
        end else begin
          if (wr_en && word == DW) dout_q <= pwdata & M;
          if (wr_en && word == RW) dir_q  <= pwdata & M;
          s1_q <= gpio_in[32*b +: 32] & M;
          s2_q <= s1_q;
        end
      end

      assign rd_lane[b] = (word == DW) ? dout_q :
                          (word == RW) ? dir_q  :
                          (word == IW) ? s2_q   : '0;
      assign gpio_out[32*b +: 32] = dout_q;
      assign gpio_oe[32*b +: 32]  = dir_q;
    end else begin : g_off
      logic [31:0] unused_in;
      assign unused_in = gpio_in[32*b +: 32];
      assign rd_lane[b] = '0;
      assign gpio_out[32*b +: 32] = '0;
      assign gpio_oe[32*b +: 32]  = '0;
    end
  end

  always_comb begin
    prdata = '0;
    if (psel)
      for (int b = 0; b < NB; b++) prdata = prdata | rd_lane[b];
  end

endmodule

// File: rtl/gpio_banks_chk.sv
module gpio_banks_chk #(
  parameter int           ADDR_W   = 8,
  parameter logic [127:0] PIN_MASK = '1
) (
  input logic              pclk,
  input logic              presetn,
  input logic              psel,
  input logic              penable,
  input logic              pwrite,
  input logic [ADDR_W-3:0] word,
  input logic [31:0]       pwdata,
  input logic [31:0]       prdata,
  input logic [31:0]       in0,
  input logic [127:0]      gpio_out,
  input logic [127:0]      gpio_oe
);

  logic [1:0] age;
  logic       wr;

  assign wr = psel && penable && pwrite;

  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn)       age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  AST_RESET_IDLE: assert property (@(posedge pclk) disable iff (!presetn)
    $rose(presetn) |-> (gpio_out == '0 && gpio_oe == '0)); // R6

  AST_DATA_WRITE: assert property (@(posedge pclk) disable iff (!presetn)
    (wr && word == '0) |=> gpio_out[31:0] == ($past(pwdata) & PIN_MASK[31:0])); // R1

  AST_DIR_WRITE: assert property (@(posedge pclk) disable iff (!presetn)
    (wr && word == (ADDR_W-2)'(1)) |=> gpio_oe[31:0] == ($past(pwdata) & PIN_MASK[31:0])); // R2

  AST_SYNC_DELAY: assert property (@(posedge pclk) disable iff (!presetn)
    (age == 2'd3 && psel && !pwrite && word == (ADDR_W-2)'(20))
      |-> prdata == ($past(in0, 2) & PIN_MASK[31:0])); // R3

  AST_UNUSED_LOW: assert property (@(posedge pclk) disable iff (!presetn)
    ((gpio_out | gpio_oe) & ~PIN_MASK) == '0); // R4

  AST_HOLD_IDLE: assert property (@(posedge pclk) disable iff (!presetn)
    !wr |=> ($stable(gpio_out) && $stable(gpio_oe))); // R8

endmodule

bind gpio_banks gpio_banks_chk #(.ADDR_W(ADDR_W), .PIN_MASK(PIN_MASK)) u_chk (
  .pclk    (pclk),
  .presetn (presetn),
  .psel    (psel),
  .penable (penable),
  .pwrite  (pwrite),
  .word    (paddr[ADDR_W-1:2]),
  .pwdata  (pwdata),
  .prdata  (prdata),
  .in0     (gpio_in[31:0]),
  .gpio_out(gpio_out),
  .gpio_oe (gpio_oe)
);

// File: tb/gpio_banks_tb.sv
`timescale 1ns/1ps
module gpio_banks_tb;

  logic         pclk = 1'b0;
  logic         presetn = 1'b0;
  logic         psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [7:0]   paddr = '0;
  logic [31:0]  pwdata = '0;
  logic [31:0]  prdata;
  logic         pready, pslverr;
  logic [127:0] gpio_in = '0;
  logic [127:0] gpio_out, gpio_oe;

  int checks = 0;
  int errors = 0;
  logic rsp_ok;

  always #10 pclk = ~pclk;

  gpio_banks u_dut (
    .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .pready(pready), .pslverr(pslverr), .gpio_in(gpio_in),
    .gpio_out(gpio_out), .gpio_oe(gpio_oe)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apb_write(input logic [7:0] a, input logic [31:0] d);
    psel = 1'b1; pwrite = 1'b1; penable = 1'b0; paddr = a; pwdata = d;
    @(negedge pclk) penable = 1'b1;
    @(negedge pclk) begin psel = 1'b0; penable = 1'b0; pwrite = 1'b0; end
  endtask

  task automatic apb_read(input logic [7:0] a, output logic [31:0] d);
    psel = 1'b1; pwrite = 1'b0; penable = 1'b0; paddr = a;
    @(negedge pclk) penable = 1'b1;
    #5 d = prdata;
    rsp_ok = pready && !pslverr;
    @(negedge pclk) begin psel = 1'b0; penable = 1'b0; end
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R6 out", gpio_out[31:0] | gpio_out[63:32] | gpio_out[127:96], 32'h0);
    check("R6 oe", gpio_oe[31:0] | gpio_oe[63:32] | gpio_oe[127:96], 32'h0);
    apb_read(8'h00, d); check("R6 data0", d, 32'h0);
    apb_read(8'h28, d); check("R6 dir3", d, 32'h0);
  endtask

  task automatic t_data();
    logic [31:0] d;
    apb_write(8'h00, 32'h0000_00A5);
    check("R1 pins0", gpio_out[31:0], 32'hA5);
    apb_read(8'h00, d); check("R1 read0", d, 32'hA5);
    check("R7 response", {31'd0, rsp_ok}, 32'h1);
    apb_write(8'h0C, 32'h0000_1234);
    check("R1 pins1", gpio_out[63:32], 32'h1234);
    check("R1 bank0 kept", gpio_out[31:0], 32'hA5);
    apb_write(8'h00, 32'hFFFF_FFFF);
    apb_read(8'h00, d); check("R4 read0 masked", d, 32'hFF);
    apb_write(8'h24, 32'hFFFF_FFFF);
    check("R4 pins3 masked", gpio_out[127:96], 32'h3FFF_FFFF);
    apb_read(8'h27, d); check("R9 lsb ignored", d, 32'h3FFF_FFFF);
  endtask

  task automatic t_dir();
    logic [31:0] d;
    apb_write(8'h04, 32'h0000_000F);
    check("R2 oe0", gpio_oe[31:0], 32'h0F);
    apb_read(8'h04, d); check("R2 read0", d, 32'h0F);
    apb_write(8'h28, 32'hC000_0001);
    check("R4 oe3", gpio_oe[127:96], 32'h1);
    apb_read(8'h28, d); check("R2 read3", d, 32'h1);
  endtask

  task automatic t_input();
    logic [31:0] d;
    gpio_in = '0;
    repeat (3) @(negedge pclk);
    gpio_in[31:0] = 32'h0000_003C;
    apb_read(8'h50, d); check("R3 before second edge", d, 32'h0);
    apb_read(8'h50, d); check("R3 after sync", d, 32'h3C);
    gpio_in[63:32]  = 32'hABCD_BEEF;
    gpio_in[127:96] = 32'hFFFF_FFFF;
    repeat (3) @(negedge pclk);
    apb_read(8'h54, d); check("R3 bank1", d, 32'hBEEF);
    apb_read(8'h5C, d); check("R4 bank3 sample", d, 32'h3FFF_FFFF);
  endtask

  task automatic t_absent();
    logic [31:0] d;
    gpio_in[95:64] = 32'hFFFF_FFFF;
    apb_write(8'h18, 32'hFFFF_FFFF);
    apb_write(8'h1C, 32'hFFFF_FFFF);
    check("R5 pins2", gpio_out[95:64] | gpio_oe[95:64], 32'h0);
    apb_read(8'h18, d); check("R5 data2", d, 32'h0);
    repeat (3) @(negedge pclk);
    apb_read(8'h58, d); check("R5 sample2", d, 32'h0);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    apb_write(8'h08, 32'hFFFF_FFFF);
    apb_write(8'h40, 32'hFFFF_FFFF);
    apb_read(8'h08, d); check("R9 word2", d, 32'h0);
    apb_read(8'h30, d); check("R9 gap", d, 32'h0);
    apb_read(8'h60, d); check("R9 high", d, 32'h0);
    apb_read(8'h00, d); check("R9 data0 kept", d, 32'hFF);
    apb_read(8'h04, d); check("R9 dir0 kept", d, 32'h0F);
  endtask

  task automatic t_nowrite();
    logic [31:0] d;
    apb_write(8'h50, 32'h0000_0000);
    check("R8 sample write out", gpio_out[31:0], 32'hFF);
    apb_read(8'h50, d); check("R8 sample write read", d, 32'h3C);
    psel = 1'b1; pwrite = 1'b1; paddr = 8'h00; pwdata = 32'h11;
    @(negedge pclk) begin psel = 1'b0; pwrite = 1'b0; end
    check("R8 setup only", gpio_out[31:0], 32'hFF);
    penable = 1'b1; pwrite = 1'b1; paddr = 8'h04; pwdata = 32'h0;
    @(negedge pclk) begin penable = 1'b0; pwrite = 1'b0; end
    check("R8 no psel", gpio_oe[31:0], 32'h0F);
  endtask

  initial begin
    repeat (3) @(negedge pclk);
    presetn = 1'b1;
    @(negedge pclk);
    t_reset();
    t_data();
    t_dir();
    t_input();
    t_absent();
    t_unmapped();
    t_nowrite();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge pclk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule